// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Slice

This block multiplies two operands and folds each product into a running sum. The sum lives in an accumulator register that is always present. Each operand first passes through an input register. On every cycle that register takes either its own parallel data port or the operand arriving from the neighbouring slice, so a row of slices can pass operands along like a shift register. The content of each operand register is always driven out on a cascade port for the next slice.

Three control bits may change on every cycle. They select signed or unsigned operands, add or subtract, and load, which replaces the sum with the product. These bits travel through the same optional register stages as the operands, so each one acts on the product it arrived with. Two parameters decide whether the input stage and the stage between multiplier and accumulator are registered. The accumulator carries guard bits above the full product width. A registered overflow flag reports when the last update did not fit. The input stage, the pipeline stage and the accumulator each have their own clock enable and synchronous reset.

Top module: `mac_slice`

## Requirements
- R1: With add selected (`sub_mode`=0, `load_mode`=0), the accumulator becomes its previous value plus the product. Operands are read as two's complement when `sgn_mode`=1 and as unsigned when `sgn_mode`=0. A signed product is sign-extended to the accumulator width and an unsigned product is zero-extended.
- R2: With `sub_mode`=1 and `load_mode`=0, the accumulator becomes its previous value minus the product, extended the same way.
- R3: With `load_mode`=1, the accumulator takes the extended product in place of the sum and the overflow flag is cleared.
- R4: In unsigned mode, `ovf_out` is 1 after an add that carries out of the top accumulator bit or a subtract that borrows, and 0 otherwise.
- R5: In signed mode, `ovf_out` is 1 when the exact signed result of the add or subtract lies outside the accumulator's two's complement range, and 0 otherwise.
- R6: The operands and controls applied on one enabled edge reach `acc_out`/`ovf_out` after IN_REG + PIPE_REG + 1 enabled edges. The controls stay aligned with their operands.
- R7: Each operand input stage takes the cascade input when its shift select is 1 and the data port when it is 0. The cascade output shows the input register's content, or the selected operand when the input stage is bypassed.
- R8: With all clock enables low and no reset, every stage holds its value: `acc_out`, `ovf_out` and both cascade outputs stay unchanged.
- R9: Synchronous reset clears the registered operands, the controls, the pipeline stage, the accumulator and the overflow flag to 0.
- R10: On overflow, the accumulator keeps the low ACCW bits of the result (wrap-around, no saturation).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ce_in | input | 1 | Clock enable, operand and control input stage |
| rst_in | input | 1 | Synchronous reset, input stage |
| ce_pipe | input | 1 | Clock enable, product pipeline stage |
| rst_pipe | input | 1 | Synchronous reset, pipeline stage |
| ce_acc | input | 1 | Clock enable, accumulator and overflow flag |
| rst_acc | input | 1 | Synchronous reset, accumulator and overflow flag |
| a_data | input | AW | Operand A parallel data |
| a_shift_sel | input | 1 | 1: operand A taken from `a_shift_in` |
| a_shift_in | input | AW | Operand A from the preceding slice |
| a_shift_out | output | AW | Operand A passed to the next slice |
| b_data | input | BW | Operand B parallel data |
| b_shift_sel | input | 1 | 1: operand B taken from `b_shift_in` |
| b_shift_in | input | BW | Operand B from the preceding slice |
| b_shift_out | output | BW | Operand B passed to the next slice |
| sgn_mode | input | 1 | 1: signed operands, 0: unsigned |
| sub_mode | input | 1 | 1: subtract product, 0: add |
| load_mode | input | 1 | 1: replace the sum with the product |
| acc_out | output | AW+BW+GUARD | Accumulated value |
| ovf_out | output | 1 | Registered overflow of the last update |

## Verification
The bench runs four copies of the slice, one for each setting of the two stage parameters. It drives them all with the same mixed stream of signed and unsigned cycles, add and subtract cycles, load cycles and stalls. Directed runs push a signed sum past its positive limit and drive unsigned sums into a carry and into a borrow. A slice that tested overflow with the wrong signedness would flag a borrow as a signed overflow, or miss it. A slice whose controls did not follow its operand pipeline would apply one cycle's add/subtract choice to the wrong product, and the sum would differ after a single cycle. Cascade selects, a reset in the middle of the run and clock-enable stalls are also checked: a stall that leaked would advance the sum, and a wrongly wired cascade would output the wrong operand.

// File: rtl/mac_slice_pkg.sv
package mac_slice_pkg;
  typedef struct packed {
    logic sgn;
    logic sub;
    logic load;
  } mac_ctrl_t;
  localparam int CTRL_W = 3;
endpackage

// File: rtl/mac_stage.sv
module mac_stage #(
  parameter int W       = 8,
  parameter bit USE_REG = 1'b1
) (
  input  logic         clk,
  input  logic         ce,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (USE_REG) begin : g_reg
      logic [W-1:0] r;
      always_ff @(posedge clk) begin
        if (rst)     r <= '0;
        else if (ce) r <= d;
      end
      assign q = r;
    end else begin : g_wire
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/mac_operand_reg.sv
module mac_operand_reg #(
  parameter int W       = 18,
  parameter bit USE_REG = 1'b1
) (
  input  logic         clk,
  input  logic         ce,
  input  logic         rst,
  input  logic         shift_sel,
  input  logic [W-1:0] par_in,
  input  logic [W-1:0] shift_in,
  output logic [W-1:0] q,
  output logic [W-1:0] shift_out
);
  logic [W-1:0] sel_val;
  assign sel_val = shift_sel ? shift_in : par_in;

  generate
    if (USE_REG) begin : g_reg
      logic [W-1:0] r;
      always_ff @(posedge clk) begin
        if (rst)     r <= '0;
        else if (ce) r <= sel_val;
      end
      assign q = r;

      // R7
      shift_load_chk: assert property (@(posedge clk) disable iff (rst)
        ce |=> (shift_out == $past(sel_val)));
    end else begin : g_wire
      assign q = sel_val;
    end
  endgenerate

  assign shift_out = q;
endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int AW = 18,
  parameter int BW = 18,
  localparam int PW = AW + BW
) (
  input  logic [AW-1:0] a,
  input  logic [BW-1:0] b,
  input  logic          sgn,
  output logic [PW-1:0] prod
);
  function automatic logic [PW-1:0] mul_fn(input logic [AW-1:0] x,
                                           input logic [BW-1:0] y,
                                           input logic          s);
    logic signed [AW:0]   xe;
    logic signed [BW:0]   ye;
    logic signed [PW+1:0] full;
    xe   = {s & x[AW-1], x};
    ye   = {s & y[BW-1], y};
    full = xe * ye;
    return full[PW-1:0];
  endfunction

  assign prod = mul_fn(a, b, sgn);
endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_slice_pkg::*;
#(
  parameter int PW    = 36,
  parameter int GUARD = 16,
  localparam int ACCW = PW + GUARD
) (
  input  logic            clk,
  input  logic            ce,
  input  logic            rst,
  input  logic [PW-1:0]   prod,
  input  mac_ctrl_t       ctrl,
  output logic [ACCW-1:0] acc,
  output logic            ovf
);
  function automatic logic [ACCW-1:0] extend_fn(input logic [PW-1:0] p,
                                                input logic          s);
    return s ? {{GUARD{p[PW-1]}}, p} : {{GUARD{1'b0}}, p};
  endfunction

  // returns {overflow, result}
  function automatic logic [ACCW:0] step_fn(input logic [ACCW-1:0] old,
                                            input logic [ACCW-1:0] ext,
                                            input logic            s,
                                            input logic            sb);
    logic [ACCW:0] sum;
    logic          s_ov;
    sum  = sb ? ({1'b0, old} - {1'b0, ext}) : ({1'b0, old} + {1'b0, ext});
    s_ov = (old[ACCW-1] == (ext[ACCW-1] ^ sb)) && (sum[ACCW-1] != old[ACCW-1]);
    return {s ? s_ov : sum[ACCW], sum[ACCW-1:0]};
  endfunction

  logic [ACCW-1:0] acc_q;
  logic            ovf_q;
  logic [ACCW-1:0] ext_prod;
  logic [ACCW:0]   step_w;
  logic [ACCW-1:0] step_acc;
  logic            step_ovf;
  logic            acc_en;

  assign ext_prod = extend_fn(prod, ctrl.sgn);
  assign step_w   = step_fn(acc_q, ext_prod, ctrl.sgn, ctrl.sub);
  assign step_acc = step_w[ACCW-1:0];
  assign step_ovf = step_w[ACCW];
  assign acc_en   = ce;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else if (acc_en) begin
      if (ctrl.load) begin
        acc_q <= ext_prod;
        ovf_q <= 1'b0;
      end else begin
        acc_q <= step_acc;
        ovf_q <= step_ovf;
      end
    end
  end

  assign acc = acc_q;
  assign ovf = ovf_q;

  // R3
  load_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_en && ctrl.load) |=> (!ovf_q && acc_q == $past(ext_prod)));

  // R4
  uns_add_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !ctrl.load && !ctrl.sgn && !ctrl.sub) |=> (ovf_q == (acc_q < $past(acc_q))));

  // R4
  uns_sub_borrow_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !ctrl.load && !ctrl.sgn && ctrl.sub) |=> (ovf_q == (acc_q > $past(acc_q))));

  // R8
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_en |=> ($stable(acc_q) && $stable(ovf_q)));

  // R9
  acc_reset_chk: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && !ovf_q));
endmodule

// File: rtl/mac_slice.sv
module mac_slice
  import mac_slice_pkg::*;
#(
  parameter int AW       = 18,
  parameter int BW       = 18,
  parameter int GUARD    = 16,
  parameter bit IN_REG   = 1'b1,
  parameter bit PIPE_REG = 1'b1,
  localparam int PW      = AW + BW,
  localparam int ACCW    = PW + GUARD
) (
  input  logic            clk,
  input  logic            ce_in,
  input  logic            rst_in,
  input  logic            ce_pipe,
  input  logic            rst_pipe,
  input  logic            ce_acc,
  input  logic            rst_acc,
  input  logic [AW-1:0]   a_data,
  input  logic            a_shift_sel,
  input  logic [AW-1:0]   a_shift_in,
  output logic [AW-1:0]   a_shift_out,
  input  logic [BW-1:0]   b_data,
  input  logic            b_shift_sel,
  input  logic [BW-1:0]   b_shift_in,
  output logic [BW-1:0]   b_shift_out,
  input  logic            sgn_mode,
  input  logic            sub_mode,
  input  logic            load_mode,
  output logic [ACCW-1:0] acc_out,
  output logic            ovf_out
);
  localparam int PIPE_W = PW + CTRL_W;

  mac_ctrl_t        ctrl_in, ctrl_s1, ctrl_s2;
  logic [AW-1:0]    a_s1;
  logic [BW-1:0]    b_s1;
  logic [PW-1:0]    prod_s1, prod_s2;
  logic [PIPE_W-1:0] pipe_d, pipe_q;

  assign ctrl_in = '{sgn: sgn_mode, sub: sub_mode, load: load_mode};

  mac_operand_reg #(.W(AW), .USE_REG(IN_REG)) u_opa (
    .clk(clk), .ce(ce_in), .rst(rst_in), .shift_sel(a_shift_sel),
    .par_in(a_data), .shift_in(a_shift_in), .q(a_s1), .shift_out(a_shift_out));

  mac_operand_reg #(.W(BW), .USE_REG(IN_REG)) u_opb (
    .clk(clk), .ce(ce_in), .rst(rst_in), .shift_sel(b_shift_sel),
    .par_in(b_data), .shift_in(b_shift_in), .q(b_s1), .shift_out(b_shift_out));

  mac_stage #(.W(CTRL_W), .USE_REG(IN_REG)) u_ctrl_in (
    .clk(clk), .ce(ce_in), .rst(rst_in), .d(ctrl_in), .q(ctrl_s1));

  mac_mult #(.AW(AW), .BW(BW)) u_mult (
    .a(a_s1), .b(b_s1), .sgn(ctrl_s1.sgn), .prod(prod_s1));

  assign pipe_d = {prod_s1, ctrl_s1};

  mac_stage #(.W(PIPE_W), .USE_REG(PIPE_REG)) u_pipe (
    .clk(clk), .ce(ce_pipe), .rst(rst_pipe), .d(pipe_d), .q(pipe_q));

  assign prod_s2 = pipe_q[PIPE_W-1:CTRL_W];
  assign ctrl_s2 = pipe_q[CTRL_W-1:0];

  mac_accum #(.PW(PW), .GUARD(GUARD)) u_acc (
    .clk(clk), .ce(ce_acc), .rst(rst_acc), .prod(prod_s2), .ctrl(ctrl_s2),
    .acc(acc_out), .ovf(ovf_out));
endmodule

// File: tb/mac_slice_bench.sv
`timescale 1ns/1ps
module mac_slice_bench;
  localparam int AW   = 9;
  localparam int BW   = 9;
  localparam int G    = 2;
  localparam int ACCW = AW + BW + G;
  localparam longint MOD  = longint'(1) << ACCW;
  localparam longint HALF = longint'(1) << (ACCW - 1);

  typedef struct packed {
    logic [AW-1:0] a;
    logic [BW-1:0] b;
    logic sgn;
    logic sub;
    logic load;
  } op_s;

  typedef struct {
    longint acc;
    bit     ovf;
  } res_s;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, ce = 1'b1;
  logic [AW-1:0] a_dat = '0, a_sin = '0;
  logic [BW-1:0] b_dat = '0, b_sin = '0;
  logic a_ssel = 1'b0, b_ssel = 1'b0;
  logic sgn = 1'b0, sub = 1'b0, ld = 1'b0;
  bit run = 1'b0, done = 1'b0;

  logic [AW-1:0] a_cur;
  logic [BW-1:0] b_cur;
  assign a_cur = a_ssel ? a_sin : a_dat;
  assign b_cur = b_ssel ? b_sin : b_dat;

  function automatic res_s apply_op(longint acc, op_s o);
    res_s   rs;
    longint av, bv, p, accv, r;
    av   = (o.sgn && o.a[AW-1]) ? longint'(o.a) - (longint'(1) << AW) : longint'(o.a);
    bv   = (o.sgn && o.b[BW-1]) ? longint'(o.b) - (longint'(1) << BW) : longint'(o.b);
    p    = av * bv;
    accv = (o.sgn && acc >= HALF) ? acc - MOD : acc;
    if (o.load) r = p;
    else if (o.sub) r = accv - p;
    else r = accv + p;
    if (o.load) rs.ovf = 1'b0;
    else if (o.sgn) rs.ovf = (r < -HALF) || (r >= HALF);
    else rs.ovf = (r < 0) || (r >= MOD);
    rs.acc = ((r % MOD) + MOD) % MOD;
    return rs;
  endfunction

  for (genvar gi = 0; gi < 4; gi++) begin : g_cfg
    localparam bit IR = (gi % 2) == 1;
    localparam bit PR = (gi / 2) == 1;
    localparam int D  = int'(IR) + int'(PR);

    logic [ACCW-1:0] acc_o;
    logic            ovf_o;
    logic [AW-1:0]   a_so;
    logic [BW-1:0]   b_so;

    mac_slice #(.AW(AW), .BW(BW), .GUARD(G), .IN_REG(IR), .PIPE_REG(PR)) u_mac_slice (
      .clk(clk), .ce_in(ce), .rst_in(rst), .ce_pipe(ce), .rst_pipe(rst),
      .ce_acc(ce), .rst_acc(rst),
      .a_data(a_dat), .a_shift_sel(a_ssel), .a_shift_in(a_sin), .a_shift_out(a_so),
      .b_data(b_dat), .b_shift_sel(b_ssel), .b_shift_in(b_sin), .b_shift_out(b_so),
      .sgn_mode(sgn), .sub_mode(sub), .load_mode(ld),
      .acc_out(acc_o), .ovf_out(ovf_o));

    op_s    line0 = '0, line1 = '0;
    longint acc_m = 0;
    bit     ovf_m = 1'b0;
    string  tag   = "R9";
    int     n_chk = 0, n_err = 0;

    always @(posedge clk) begin
      op_s  cur, op;
      res_s rs;
      cur = '{a: a_cur, b: b_cur, sgn: sgn, sub: sub, load: ld};
      if (rst) begin
        line0 = '0; line1 = '0; acc_m = 0; ovf_m = 1'b0; tag = "R9";
      end else if (ce) begin
        op = (D == 0) ? cur : ((D == 1) ? line0 : line1);
        rs = apply_op(acc_m, op);
        acc_m = rs.acc;
        ovf_m = rs.ovf;
        if (op.load) tag = "R3";
        else if (rs.ovf) tag = op.sgn ? "R5 R10" : "R4 R10";
        else tag = op.sub ? "R2" : "R1";
        line1 = line0;
        line0 = cur;
      end else begin
        tag = "R8";
      end
    end

    always @(negedge clk) begin
      logic [AW-1:0] ea;
      logic [BW-1:0] eb;
      if (run) begin
        n_chk++;
        if (acc_o !== acc_m[ACCW-1:0] || ovf_o !== ovf_m) begin
          n_err++;
          $display("FAIL %s R6 cfg%0d: acc=%h ovf=%b expected acc=%h ovf=%b",
                   tag, gi, acc_o, ovf_o, acc_m[ACCW-1:0], ovf_m);
        end
        ea = IR ? line0.a : a_cur;
        eb = IR ? line0.b : b_cur;
        n_chk++;
        if (a_so !== ea || b_so !== eb) begin
          n_err++;
          $display("FAIL R7 cfg%0d: shift_out a=%h b=%h expected a=%h b=%h",
                   gi, a_so, b_so, ea, eb);
        end
      end
    end
  end

  task automatic step(input logic [AW-1:0] a, input logic [BW-1:0] b,
                      input logic s, input logic sb, input logic l);
    @(posedge clk); #1;
    a_dat = a; b_dat = b; sgn = s; sub = sb; ld = l;
    a_ssel = 1'b0; b_ssel = 1'b0;
  endtask

  int total_chk, total_err;

  initial begin
    repeat (3) @(posedge clk);
    #1 run = 1'b1;                          // R9 reset state checked here
    @(posedge clk); #1 rst = 1'b0;
    // R5: signed sum of (-256)*(-256) climbs past the positive limit
    step(9'h100, 9'h100, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 10; i++) step(9'h100, 9'h100, 1'b1, 1'b0, 1'b0);
    // R5: signed subtract drives below the negative limit
    for (int i = 0; i < 20; i++) step(9'h100, 9'h100, 1'b1, 1'b1, 1'b0);
    // R4: unsigned carry
    step(9'h000, 9'h000, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 6; i++) step(9'h1FF, 9'h1FF, 1'b0, 1'b0, 1'b0);
    // R4 R2: unsigned borrow from zero
    step(9'h000, 9'h000, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) step(9'h001, 9'h001, 1'b0, 1'b1, 1'b0);
    // R1 R2 R3 R7 R8: random mix
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      a_dat  = AW'($urandom); b_dat = BW'($urandom);
      a_sin  = AW'($urandom); b_sin = BW'($urandom);
      a_ssel = ($urandom % 4) == 0; b_ssel = ($urandom % 4) == 0;
      sgn    = $urandom % 2; sub = $urandom % 2;
      ld     = ($urandom % 16) == 0;
      ce     = ($urandom % 8) != 0;
      rst    = (i == 1500) || (i == 1501);  // R9 mid-run reset
    end
    @(posedge clk); #1 ce = 1'b1; rst = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); #1 run = 1'b0;
    done = 1'b1;
    total_chk = g_cfg[0].n_chk + g_cfg[1].n_chk + g_cfg[2].n_chk + g_cfg[3].n_chk;
    total_err = g_cfg[0].n_err + g_cfg[1].n_err + g_cfg[2].n_err + g_cfg[3].n_err;
    $display("Simulation finished: %0d checks, %0d errors", total_chk, total_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total_chk = g_cfg[0].n_chk + g_cfg[1].n_chk + g_cfg[2].n_chk + g_cfg[3].n_chk + 1;
      total_err = g_cfg[0].n_err + g_cfg[1].n_err + g_cfg[2].n_err + g_cfg[3].n_err + 1;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", total_chk, total_err);
      $finish;
    end
  end
endmodule